// File: doc/BRIEF.md
# Timer Interrupt Source Arbiter

This block sits between the seven capture/compare channels of a timer and the processor's interrupt controller. It latches each channel's one-cycle event pulse into a pending flag. It then drives two interrupt request lines. Channel 0 has a request line of its own, which serves the counter's wrap and match events. Channels 1 to 6 share a second request line.

Software services the shared line through a source vector. The vector holds an even code that names the highest-priority pending channel. Reading the vector, signalled by a one-cycle read strobe, retires that one channel and leaves the other pending channels in place. Channel 0 is retired through its own acknowledge strobe.

Each channel has its own enable. A global enable gates both request lines. Pending flags latch whatever the enables are set to, so an event that arrives while its channel is masked is not lost.

Top module: `tmr_irq_arb`

## Requirements
- R1: After reset, all pending flags are clear, both request lines are low and the vector reads 0.
- R2: An event pulse on a channel sets that channel's pending flag at the next clock edge. The flag stays set until that channel is retired.
- R3: The channel 0 request is high exactly when the global enable, the channel 0 enable and the channel 0 pending flag are all high. A channel 0 acknowledge strobe clears that flag at the next edge.
- R4: The shared request is high exactly when the global enable is high and at least one of channels 1 to 6 is both pending and enabled.
- R5: While the global enable is low, both request lines stay low. Events still latch, and their requests appear once the global enable returns high.
- R6: The vector equals 2 times the lowest-numbered channel among channels 1 to 6 that is both pending and enabled, giving codes 2, 4, 6, 8, 10 and 12. It reads 0 when no such channel exists. The vector does not depend on the global enable.
- R7: A pending channel whose enable is low is left out of both the vector and the shared request. Its flag is kept, and the channel is reported once it is enabled again.
- R8: A read strobe while the vector is nonzero clears, at the next edge, only the flag of the channel being reported.
- R9: A read strobe while the vector is 0 changes no flag.
- R10: If a new event arrives on the reported channel in the same cycle as a read strobe, that channel stays pending.
- R11: A read strobe never clears the channel 0 flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NCH (7) | One-cycle event pulse per channel; bit n is channel n |
| en_i | input | NCH (7) | Per-channel interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| vec_rd_i | input | 1 | One-cycle vector read strobe; retires the reported channel |
| ch0_ack_i | input | 1 | One-cycle acknowledge strobe for channel 0 |
| irq_ch0_o | output | 1 | Dedicated channel 0 interrupt request |
| irq_shr_o | output | 1 | Shared interrupt request for channels 1 to 6 |
| vec_o | output | VW (4) | Source vector: 2 times the reported channel, or 0 |

## Verification
Event, read and acknowledge strobes act through one register stage, so their effects are due one edge after the cycle in which they are driven. The enables and the global enable act on the outputs combinationally from the flags within the same cycle. The bench drives all inputs at the falling edge. For each step, a driver computes the expected request lines and vector after the following rising edge and queues them. A monitor pops and compares those values shortly after that rising edge. Because every comparison lands one edge after its stimulus, both the registered and the combinational paths are checked at the cycle where they become due.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned CH_NUM = 7;

  // bits needed for codes 0 .. 2*(n-1)
  function automatic int unsigned vec_bits(int unsigned n);
    return $clog2(2 * (n - 1) + 1);
  endfunction
endpackage

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_o[g] <= 1'b0;
      else if (set_i[g])   pend_o[g] <= 1'b1;  // a new event wins over a clear
      else if (clr_i[g])   pend_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_irq_prio.sv
module tmr_irq_prio #(
  parameter int unsigned M  = 6,
  parameter int unsigned VW = 4
) (
  input  logic [M-1:0]  req_i,   // bit j = channel j+1
  output logic [VW-1:0] code_o,
  output logic [M-1:0]  sel_o
);
  always_comb begin
    code_o = '0;
    sel_o  = '0;
    for (int j = M - 1; j >= 0; j--) begin
      if (req_i[j]) begin
        code_o   = VW'(2 * (j + 1));
        sel_o    = '0;
        sel_o[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb #(
  parameter int unsigned NCH = tmr_irq_pkg::CH_NUM,
  localparam int unsigned VW = tmr_irq_pkg::vec_bits(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt_i,
  input  logic [NCH-1:0] en_i,
  input  logic           gie_i,
  input  logic           vec_rd_i,
  input  logic           ch0_ack_i,
  output logic           irq_ch0_o,
  output logic           irq_shr_o,
  output logic [VW-1:0]  vec_o
);
  localparam int unsigned NSH = NCH - 1;

  logic [NCH-1:0] pend;
  logic [NCH-1:0] clr;
  logic [NSH-1:0] shr_req;
  logic [NSH-1:0] shr_sel;

  assign shr_req = pend[NCH-1:1] & en_i[NCH-1:1];

  tmr_irq_prio #(.M(NSH), .VW(VW)) u_prio (
    .req_i (shr_req),
    .code_o(vec_o),
    .sel_o (shr_sel)
  );

  assign clr = {shr_sel & {NSH{vec_rd_i}}, ch0_ack_i};

  tmr_irq_flags #(.N(NCH)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_i),
    .clr_i (clr),
    .pend_o(pend)
  );

  assign irq_ch0_o = gie_i & en_i[0] & pend[0];
  assign irq_shr_o = gie_i & (|shr_req);
endmodule

// File: rtl/tmr_irq_arb_chk.sv
module tmr_irq_arb_chk #(
  parameter int unsigned NCH = 7,
  parameter int unsigned VW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] evt_i,
  input logic [NCH-1:0] en_i,
  input logic           gie_i,
  input logic           vec_rd_i,
  input logic           ch0_ack_i,
  input logic           irq_ch0_o,
  input logic           irq_shr_o,
  input logic [VW-1:0]  vec_o
);
  // R5
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> (!irq_ch0_o && !irq_shr_o));

  // R4
  vec_raises_shr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_i && vec_o != '0) |-> irq_shr_o);

  // R6
  vec_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o[0] == 1'b0) && (vec_o <= VW'(2 * (NCH - 1))));

  // R8
  rd_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd_i && vec_o != '0 && !evt_i[vec_o[VW-1:1]]) |=> (vec_o != $past(vec_o)));

  // R2
  ch0_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[0] && !ch0_ack_i) |=> (irq_ch0_o || !gie_i || !en_i[0]));

  // R11
  ch0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ch0_o && !ch0_ack_i) |=> (irq_ch0_o || !gie_i || !en_i[0]));
endmodule

bind tmr_irq_arb tmr_irq_arb_chk #(.NCH(NCH), .VW(VW)) u_chk (.*);

// File: tb/tmr_irq_arb_tb.sv
module tmr_irq_arb_tb;
  localparam int NCH = 7;
  localparam int VW  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] evt = '0;
  logic [NCH-1:0] en = '0;
  logic           gie = 1'b0;
  logic           rd = 1'b0;
  logic           ack = 1'b0;
  logic           irq0, irqs;
  logic [VW-1:0]  vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  tmr_irq_arb u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_i(en), .gie_i(gie),
    .vec_rd_i(rd), .ch0_ack_i(ack),
    .irq_ch0_o(irq0), .irq_shr_o(irqs), .vec_o(vec)
  );

  // scoreboard: expected {irq0, irqs, vec} and the requirement tag
  logic [VW+1:0] exp_q[$];
  string         tag_q[$];
  logic [NCH-1:0] mpend = '0;

  function automatic logic [VW-1:0] code_of(logic [NCH-1:0] p, logic [NCH-1:0] e);
    for (int c = 1; c < NCH; c++)
      if (p[c] && e[c]) return VW'(2 * c);
    return '0;
  endfunction

  task automatic step(input logic [NCH-1:0] ev, input logic [NCH-1:0] e,
                      input logic g, input logic r, input logic a, input string tag);
    logic [VW-1:0] cur;
    logic [VW-1:0] nv;
    @(negedge clk);
    evt = ev; en = e; gie = g; rd = r; ack = a;
    cur = code_of(mpend, e);
    if (r && cur != '0) mpend[cur >> 1] = 1'b0;
    if (a) mpend[0] = 1'b0;
    mpend = mpend | ev;
    nv = code_of(mpend, e);
    exp_q.push_back({g & e[0] & mpend[0], g & (nv != '0), nv});
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [VW+1:0] ex;
      string t;
      ex = exp_q.pop_front();
      t  = tag_q.pop_front();
      checks++;
      if ({irq0, irqs, vec} !== ex) begin
        errors++;
        $display("FAIL %s: got irq0=%b irqs=%b vec=%0d expected irq0=%b irqs=%b vec=%0d",
                 t, irq0, irqs, vec, ex[VW+1], ex[VW], ex[VW-1:0]);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [NCH-1:0] ALL = '1;
  localparam logic [NCH-1:0] NONE = '0;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({irq0, irqs, vec} !== '0) begin
      errors++;
      $display("FAIL R1: got irq0=%b irqs=%b vec=%0d expected 0 0 0", irq0, irqs, vec);
    end
    @(negedge clk); rst_n = 1'b1;

    step(NONE, ALL, 1, 0, 0, "R1 idle");
    step(7'b0001000, ALL, 1, 0, 0, "R2 R4 R6 ch3 set");
    step(NONE, ALL, 1, 0, 0, "R2 ch3 held");
    step(7'b0000010, ALL, 1, 0, 0, "R6 ch1 priority");
    step(NONE, ALL, 1, 1, 0, "R8 read retires ch1");
    step(NONE, ALL, 0, 0, 0, "R5 gie low");
    step(7'b0000001, ALL, 0, 0, 0, "R5 ch0 latched gated");
    step(NONE, ALL, 1, 0, 0, "R3 R5 ch0 request");
    step(NONE, ALL, 1, 1, 0, "R11 read keeps ch0");
    step(NONE, ALL, 1, 0, 0, "R11 ch0 held");
    step(NONE, 7'b1111110, 1, 0, 0, "R3 ch0 masked");
    step(NONE, ALL, 1, 0, 1, "R3 ch0 ack");
    step(7'b0000100, 7'b1111011, 1, 0, 0, "R7 ch2 masked");
    step(NONE, 7'b1111011, 1, 1, 0, "R9 read with vec 0");
    step(NONE, ALL, 1, 0, 0, "R7 R9 ch2 unmasked");
    step(7'b0000100, ALL, 1, 1, 0, "R10 read with new event");
    step(NONE, ALL, 1, 1, 0, "R8 retire ch2");
    step(7'b1111110, ALL, 1, 0, 0, "R6 all shared pending");
    for (int k = 0; k < 6; k++) step(NONE, ALL, 1, 1, 0, "R6 R8 drain in order");
    step(7'b1010000, 7'b0101111, 1, 0, 0, "R7 ch4 ch6 masked");
    step(NONE, ALL, 1, 0, 0, "R7 ch4 reported");
    step(NONE, ALL, 1, 1, 0, "R8 ch6 remains");
    step(NONE, ALL, 1, 1, 0, "R8 empty");
    step(NONE, ALL, 1, 0, 0, "R4 idle");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule